// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Chain

This block is a synchronous up-counter built from 4-bit stages that share one rising clock edge. Every stage can be cleared to zero at once, with no clock edge needed, through an active-low clear. It can be preset from a parallel data input on the next clock edge through an active-low load, and it advances by one when two independent count enables are both high. A carry output marks the moment the count reaches its top value. That carry is qualified only by the second (chain) enable, and it is the signal that drives the next stage.

A generate loop chains a parameterised number of stages. Stage 0 takes its chain enable from the block input. Each later stage takes it from the carry of the stage below. The chain therefore forms a wider counter that still changes state on a single edge, with no gating added between stages. The common count enable and the load go to every stage. The carry of the top stage is the block's carry output, so several blocks can be chained in the same way.

Top module: `cnt_chain`

## Requirements
- R1: While `clear_n` is low, `count` is zero at once, without waiting for a clock edge, whatever the levels of `load_n`, `cnt_en`, `chain_en` and `din`.
- R2: With `clear_n` high and `load_n` low, `count` takes the value of `din` at the next rising edge, whatever the levels of `cnt_en` and `chain_en`.
- R3: With `clear_n` and `load_n` high and both `cnt_en` and `chain_en` high, `count` increases by one at the next rising edge.
- R4: With `clear_n` and `load_n` high and either `cnt_en` or `chain_en` low, `count` keeps its value across the rising edge.
- R5: `carry_out` is high exactly when `chain_en` is high and every bit of `count` is 1. It follows `chain_en` with no clock edge and does not depend on `cnt_en`.
- R6: A count step from the all-ones value gives zero (the count wraps modulo 2 to the power of the width).
- R7: The chain enable of stage i (i > 0) is the carry of stage i-1. With two stages, the block counts as one 8-bit counter: bits [3:0] carry into bits [7:4] on the same edge, for example 0x0F goes to 0x10 and 0xFF goes to 0x00.
- R8: A single 4-bit stage preset to 12 and then stepped six times shows 13, 14, 15, 0, 1, 2, with `carry_out` high only at 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| clear_n | input | 1 | Asynchronous clear, active low; forces the count to zero |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by every stage; does not affect the carry |
| chain_en | input | 1 | Count enable for stage 0 that also qualifies the carry |
| din | input | STAGES*STAGE_W | Preset value loaded when `load_n` is low |
| count | output | STAGES*STAGE_W | Current count value |
| carry_out | output | 1 | High when the count is all ones and `chain_en` is high |

## Verification
The bench applies clear while load is active, loads values with both enables low, holds with each enable low on its own, and counts through the 4-bit and 8-bit wrap points. These cases separate the priority order from a design that lets load or the enables win over clear. Toggling `cnt_en` and `chain_en` alone at the all-ones value, between clock edges, shows whether the carry is combinational and ignores the shared enable. Stepping 0x0F and 0xFE across an edge tests whether the lower carry reaches the upper stage in the same cycle. A long run of random control patterns, compared with a reference model for the 8-bit chain and a single stage, covers the mixed orderings of these cases.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int unsigned NIBBLE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic load_n;
        logic en_p;
        logic en_t;
    } cnt_ctl_t;

    // Synchronous priority: load first, then count, then hold.
    // The asynchronous clear sits above all of these in the stage itself.
    function automatic cnt_op_e pick_op(input cnt_ctl_t c);
        if (!c.load_n)
            return OP_LOAD;
        else if (c.en_p && c.en_t)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_op_dec.sv
module cnt_op_dec
    import cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W = NIBBLE_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] TOP  = '1;

    cnt_ctl_t ctl;
    cnt_op_e  op;
    logic [W-1:0] q_next;

    assign ctl = '{load_n: load_n, en_p: en_p, en_t: en_t};

    cnt_op_dec u_dec (
        .ctl (ctl),
        .op  (op)
    );

    always_comb begin
        unique case (op)
            OP_LOAD:  q_next = d;
            OP_COUNT: q_next = q + ONE;
            default:  q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            q <= ZERO;
        else
            q <= q_next;
    end

    // Carry depends on the state and the chain enable only.
    assign carry = en_t && (q == TOP);

    // R1: clear holds the state at zero
    p_clear_zero_r1: assert property (@(posedge clk) !clear_n |-> q == ZERO)
        else $error("p_clear_zero_r1");

    // R2: load takes data regardless of enables
    p_load_r2: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> q == $past(d))
        else $error("p_load_r2");

    // R3: step by one
    p_step_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_p && en_t) |=> q == $past(q) + ONE)
        else $error("p_step_r3");

    // R4: hold when an enable is low
    p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_p && en_t)) |=> $stable(q))
        else $error("p_hold_r4");

    // R5: carry never appears without the chain enable
    p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clear_n)
        carry |-> en_t)
        else $error("p_carry_gate_r5");

    // R6: wrap to zero from the top value
    p_wrap_r6: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_p && en_t && q == TOP) |=> q == ZERO)
        else $error("p_wrap_r6");

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned STAGE_W = NIBBLE_W
) (
    input  logic                        clk,
    input  logic                        clear_n,
    input  logic                        load_n,
    input  logic                        cnt_en,
    input  logic                        chain_en,
    input  logic [STAGES*STAGE_W-1:0]   din,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_out
);
    localparam int unsigned TOT_W = STAGES * STAGE_W;
    localparam logic [TOT_W-1:0] ALL_ONES = '1;

    logic [STAGES-1:0] t_in;
    logic [STAGES-1:0] c_out;

    assign t_in[0] = chain_en;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i > 0) begin : g_link
                assign t_in[i] = c_out[i-1];
            end
            cnt_stage #(.W(STAGE_W)) u_stage (
                .clk     (clk),
                .clear_n (clear_n),
                .load_n  (load_n),
                .en_p    (cnt_en),
                .en_t    (t_in[i]),
                .d       (din[i*STAGE_W +: STAGE_W]),
                .q       (count[i*STAGE_W +: STAGE_W]),
                .carry   (c_out[i])
            );
        end
    endgenerate

    assign carry_out = c_out[STAGES-1];

    // R7: the chain behaves as one wide counter that wraps as a whole
    p_chain_wrap_r7: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && chain_en && count == ALL_ONES) |=> count == '0)
        else $error("p_chain_wrap_r7");

    // R5: top carry only at the full-width top value
    p_chain_carry_r5: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> (count == ALL_ONES && chain_en))
        else $error("p_chain_carry_r5");

endmodule

// File: tb/cnt_chain_test.sv
module cnt_chain_test;

    typedef struct {
        logic [7:0] e8;
        logic       c8;
        logic [3:0] e4;
        logic       c4;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       clear_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] count8;
    logic [3:0] count4;
    logic       carry8;
    logic       carry4;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] m8 = 8'h00;
    logic [3:0] m4 = 4'h0;
    sb_item_t sbq[$];

    always #5 clk = ~clk;

    cnt_chain #(.STAGES(2), .STAGE_W(4)) uut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count(count8), .carry_out(carry8)
    );

    cnt_chain #(.STAGES(1), .STAGE_W(4)) uut_nib (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din[3:0]), .count(count4), .carry_out(carry4)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of controls at a falling edge and queues
    // the expected result after the following rising edge.
    task automatic apply(input logic ld_n, input logic p, input logic t,
                         input logic [7:0] d, input string tag);
        sb_item_t it;
        load_n = ld_n; cnt_en = p; chain_en = t; din = d;
        if (!ld_n) begin
            m8 = d; m4 = d[3:0];
        end else if (p && t) begin
            m8 = m8 + 8'd1; m4 = m4 + 4'd1;
        end
        it.e8 = m8; it.c8 = t && (m8 == 8'hFF);
        it.e4 = m4; it.c4 = t && (m4 == 4'hF);
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares two time units after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                chk({it.tag, " count8"}, 32'(count8), 32'(it.e8));
                chk({it.tag, " carry8"}, 32'(carry8), 32'(it.c8));
                chk({it.tag, " count4"}, 32'(count4), 32'(it.e4));
                chk({it.tag, " carry4"}, 32'(carry4), 32'(it.c4));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state (R1)
        repeat (2) @(negedge clk);
        #1;
        chk("R1 reset count8", 32'(count8), 32'h0);
        chk("R1 reset carry8", 32'(carry8), 32'h0);
        @(negedge clk);
        clear_n = 1'b1;
        m8 = 8'h00; m4 = 4'h0;

        // R2: load with both enables low, and with both high
        apply(1'b0, 1'b0, 1'b0, 8'hA5, "R2 load en low");
        apply(1'b0, 1'b1, 1'b1, 8'h3C, "R2 load en high");
        // R4: hold with each enable low on its own
        apply(1'b1, 1'b0, 1'b1, 8'h00, "R4 hold p low");
        apply(1'b1, 1'b1, 1'b0, 8'h00, "R4 hold t low");
        // R3: counting
        apply(1'b1, 1'b1, 1'b1, 8'h00, "R3 step");
        apply(1'b1, 1'b1, 1'b1, 8'h00, "R3 step");

        // R8: preset 12 then six steps on the 4-bit stage
        apply(1'b0, 1'b0, 1'b0, 8'h0C, "R8 preset");
        for (int i = 0; i < 6; i++) apply(1'b1, 1'b1, 1'b1, 8'h00, "R8 sequence");

        // R7: carry from lower into upper stage
        apply(1'b0, 1'b0, 1'b0, 8'h0F, "R7 preset 0F");
        apply(1'b1, 1'b1, 1'b0, 8'h00, "R7 hold t low at 0F");
        apply(1'b1, 1'b1, 1'b1, 8'h00, "R7 0F to 10");
        apply(1'b0, 1'b0, 1'b0, 8'hFE, "R7 preset FE");
        apply(1'b1, 1'b1, 1'b1, 8'h00, "R7 FE to FF");
        apply(1'b1, 1'b1, 1'b1, 8'h00, "R6 wrap FF to 00");

        // R5: carry combinational, independent of cnt_en
        apply(1'b0, 1'b0, 1'b0, 8'hFF, "R5 preset FF");
        apply(1'b1, 1'b0, 1'b1, 8'h00, "R5 hold p low");
        #1;
        chk("R5 carry8 with p low", 32'(carry8), 32'h1);
        cnt_en = 1'b1;
        #1;
        chk("R5 carry8 p high", 32'(carry8), 32'h1);
        chain_en = 1'b0;
        #1;
        chk("R5 carry8 drops with t", 32'(carry8), 32'h0);
        chk("R5 carry4 drops with t", 32'(carry4), 32'h0);
        chain_en = 1'b1;
        #1;
        chk("R5 carry4 rises with t", 32'(carry4), 32'h1);
        cnt_en = 1'b0;
        @(negedge clk);

        // R1: clear without a clock edge, overriding load and enables
        apply(1'b0, 1'b0, 1'b0, 8'h5A, "R2 preset 5A");
        #2;
        load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; din = 8'h77;
        clear_n = 1'b0;
        #1;
        chk("R1 async clear count8", 32'(count8), 32'h0);
        chk("R1 async clear count4", 32'(count4), 32'h0);
        @(posedge clk);
        #2;
        chk("R1 clear beats load", 32'(count8), 32'h0);
        @(negedge clk);
        clear_n = 1'b1;
        m8 = 8'h00; m4 = 4'h0;

        // R3/R4 random control patterns against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            apply(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                  r, "R3/R4 random");
        end

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule